// File: doc/BRIEF.md
# Local Bus SRAM Responder

This block answers a bridge that acts as master on a local bus, and places a synchronous SRAM behind that bus. The bridge asks for the bus on a hold-request line. The responder grants it on a hold-acknowledge line, but only when no other local agent is using the bus. Each access opens with a one-clock, active-low address strobe. In that clock the responder captures the byte address, the transfer direction and the byte enables. If the word address lands inside the configured SRAM window, the responder runs one or more data beats against the SRAM. For every beat it returns a one-clock active-low ready pulse, after one fixed wait state. The access ends on the beat during which the bridge holds the last-beat flag low.

Within one tenure the bridge may issue several accesses back to back. If the bridge holds the grant without ever starting a valid access, the grant is withdrawn after a fixed number of clocks. An access whose address misses the window is ignored completely. The bridge then sees no ready pulse, and the responder never drives the data bus for it.

Top module: `lbus_sram_resp`

## Requirements
- R1: After reset, `hold_ack` is 0. It rises exactly one clock after `hold_req` is sampled at 1 with `local_busy` at 0. While `local_busy` is 1, no grant is given.
- R2: While granted with no access in progress, `hold_ack` stays high for at most TIMEOUT (default 12) clocks and then drops. It is not given again until `hold_req` has been sampled at 0.
- R3: Address `la`, direction `wr_sel` (1 = write, 0 = read) and `be_n` are captured at the clock edge where `ads_n` is sampled at 0. Changes to them after that edge have no effect on the access.
- R4: Reads pulse `sram_re` and writes pulse `sram_we`. The two are never high in the same cycle.
- R5: `be_n[i]` low enables byte i (bits 8i+7..8i) of the 32-bit word. The enables captured at the strobe apply to every beat, and disabled bytes keep their stored value.
- R6: `ready_n` is low for exactly one clock per beat. For the first beat that clock is the second after the strobe edge. For every later beat it is the second after the previous ready clock.
- R7: On a read beat, `ld_oe` is 1 and `ld_out` carries the SRAM word during the ready clock. On a write beat, `ld_oe` stays 0 and the data on `ld_in` in the ready clock is what gets stored.
- R8: Within a burst, each completed beat advances the word address by one. The access ends after the beat in which `blast_n` is sampled at 0 together with the ready clock.
- R9: The window covers byte addresses WIN_BASE to WIN_BASE+4*SRAM_WORDS-1 (defaults 0x4000 to 0x43FF). A strobe outside that range gives no ready, no `ld_oe` and no SRAM strobe, and the grant timeout keeps running.
- R10: While granted, further accesses may follow. Once the final beat is done, `hold_ack` drops one clock after `hold_req` is sampled at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_req | input | 1 | Bus request from the bridge |
| local_busy | input | 1 | Another local agent occupies the bus |
| hold_ack | output | 1 | Bus grant to the bridge |
| ads_n | input | 1 | Address strobe, active low, first clock of an access |
| blast_n | input | 1 | Last-beat flag, active low |
| wr_sel | input | 1 | Direction: 1 write, 0 read |
| be_n | input | DW/8 | Byte enables, active low |
| la | input | LA_W | Byte address |
| ld_in | input | DW | Write data from the bridge |
| ld_out | output | DW | Read data toward the bridge |
| ld_oe | output | 1 | Drive enable for ld_out |
| ready_n | output | 1 | Beat acknowledge, active low |
| sram_addr | output | clog2(SRAM_WORDS) | SRAM word address |
| sram_wdata | output | DW | SRAM write data |
| sram_be | output | DW/8 | SRAM byte write enables, active high |
| sram_we | output | 1 | SRAM write strobe |
| sram_re | output | 1 | SRAM read strobe |
| sram_rdata | input | DW | SRAM read data, one clock after sram_re |

## Verification
The hardest case to reach from the ports is the grant timeout together with an ignored access. The counter must keep running through a strobe that misses the window, and the grant must then stay withheld while the request is still held. The stimulus covers this with directed tenures. In one, the bridge strobes an address one word past the window end. In another, it strobes one word below the window base. In a third, it never strobes at all. Each of these counts the clocks of grant and watches that ready, the drive enable and the SRAM strobes stay quiet. Random tenures with random burst lengths, byte enables and post-strobe changes to address, direction and enables check that the captured values alone steer each beat.

// File: rtl/lbsr_pkg.sv
package lbsr_pkg;
  typedef enum logic [1:0] {G_IDLE, G_OWN, G_BUSY, G_REL} grant_st_t;
  typedef enum logic [1:0] {B_IDLE, B_WAIT, B_RDY} beat_st_t;
endpackage

// File: rtl/lbsr_decode.sv
module lbsr_decode #(
  parameter int LA_W       = 16,
  parameter int BEW        = 4,
  parameter int SRAM_WORDS = 256,
  parameter int WIN_BASE   = 32'h4000
) (
  input  logic [LA_W-1:0]               la,
  output logic                          hit,
  output logic [$clog2(SRAM_WORDS)-1:0] off
);
  localparam int OFF_BITS = $clog2(BEW);
  localparam int WA_W     = LA_W - OFF_BITS;
  localparam int BASE_W   = WIN_BASE / BEW;
  localparam int SRAM_AW  = $clog2(SRAM_WORDS);

  logic [WA_W-1:0] word;
  logic [WA_W:0]   rel;
  logic            unused_low;

  assign word       = la[LA_W-1:OFF_BITS];
  assign unused_low = ^la[OFF_BITS-1:0];
  // A negative distance from the base sets the top bit.
  assign rel = {1'b0, word} - (WA_W+1)'(BASE_W);
  assign hit = !rel[WA_W] && (rel < (WA_W+1)'(SRAM_WORDS));
  assign off = rel[SRAM_AW-1:0];
endmodule

// File: rtl/lbsr_grant.sv
module lbsr_grant
  import lbsr_pkg::*;
#(
  parameter int TIMEOUT = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_req,
  input  logic local_busy,
  input  logic start,
  input  logic done,
  output logic hold_ack,
  output logic owner_open,
  output logic acc_busy
);
  localparam int CW = (TIMEOUT < 2) ? 1 : $clog2(TIMEOUT);

  grant_st_t       g_st;
  logic [CW-1:0]   wait_cnt;

  assign owner_open = (g_st == G_OWN);
  assign acc_busy   = (g_st == G_BUSY);

  always_ff @(posedge clk) begin
    if (rst) begin
      g_st     <= G_IDLE;
      hold_ack <= 1'b0;
      wait_cnt <= '0;
    end else begin
      case (g_st)
        G_IDLE: begin
          if (hold_req && !local_busy) begin
            g_st     <= G_OWN;
            hold_ack <= 1'b1;
            wait_cnt <= '0;
          end
        end
        G_OWN: begin
          if (!hold_req) begin
            g_st     <= G_IDLE;
            hold_ack <= 1'b0;
          end else if (start) begin
            g_st <= G_BUSY;
          end else if (wait_cnt == CW'(TIMEOUT - 1)) begin
            g_st     <= G_REL;
            hold_ack <= 1'b0;
          end else begin
            wait_cnt <= wait_cnt + CW'(1);
          end
        end
        G_BUSY: begin
          if (done) begin
            g_st     <= G_OWN;
            wait_cnt <= '0;
          end
        end
        G_REL: begin
          if (!hold_req) g_st <= G_IDLE;
        end
        default: g_st <= G_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lbsr_beat.sv
module lbsr_beat
  import lbsr_pkg::*;
#(
  parameter int DW      = 32,
  parameter int BEW     = 4,
  parameter int SRAM_AW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               start_wr,
  input  logic [BEW-1:0]     start_be_n,
  input  logic [SRAM_AW-1:0] start_off,
  input  logic               blast_n,
  input  logic [DW-1:0]      ld_in,
  input  logic [DW-1:0]      sram_rdata,
  output logic               done,
  output logic               ready_n,
  output logic               ld_oe,
  output logic [DW-1:0]      ld_out,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic [DW-1:0]      sram_wdata,
  output logic [BEW-1:0]     sram_be,
  output logic               sram_we,
  output logic               sram_re
);
  beat_st_t           bst;
  logic               is_wr;
  logic [BEW-1:0]     be_lat;
  logic [SRAM_AW-1:0] cur;

  assign done   = (bst == B_RDY) && !blast_n;
  assign ld_out = ld_oe ? sram_rdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      bst        <= B_IDLE;
      is_wr      <= 1'b0;
      be_lat     <= '0;
      cur        <= '0;
      ready_n    <= 1'b1;
      ld_oe      <= 1'b0;
      sram_addr  <= '0;
      sram_wdata <= '0;
      sram_be    <= '0;
      sram_we    <= 1'b0;
      sram_re    <= 1'b0;
    end else begin
      sram_we <= 1'b0;
      sram_re <= 1'b0;
      case (bst)
        B_IDLE: begin
          if (start) begin
            is_wr     <= start_wr;
            be_lat    <= ~start_be_n;
            cur       <= start_off;
            sram_addr <= start_off;
            sram_re   <= ~start_wr;
            bst       <= B_WAIT;
          end
        end
        B_WAIT: begin
          ready_n <= 1'b0;
          ld_oe   <= ~is_wr;
          bst     <= B_RDY;
        end
        B_RDY: begin
          ready_n <= 1'b1;
          ld_oe   <= 1'b0;
          if (is_wr) begin
            sram_we    <= 1'b1;
            sram_addr  <= cur;
            sram_wdata <= ld_in;
            sram_be    <= be_lat;
          end
          if (!blast_n) begin
            bst <= B_IDLE;
          end else begin
            cur <= cur + SRAM_AW'(1);
            bst <= B_WAIT;
            if (!is_wr) begin
              sram_re   <= 1'b1;
              sram_addr <= cur + SRAM_AW'(1);
            end
          end
        end
        default: bst <= B_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lbus_sram_resp.sv
module lbus_sram_resp #(
  parameter int LA_W       = 16,
  parameter int DW         = 32,
  parameter int SRAM_WORDS = 256,
  parameter int WIN_BASE   = 32'h4000,
  parameter int TIMEOUT    = 12
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          hold_req,
  input  logic                          local_busy,
  output logic                          hold_ack,
  input  logic                          ads_n,
  input  logic                          blast_n,
  input  logic                          wr_sel,
  input  logic [DW/8-1:0]               be_n,
  input  logic [LA_W-1:0]               la,
  input  logic [DW-1:0]                 ld_in,
  output logic [DW-1:0]                 ld_out,
  output logic                          ld_oe,
  output logic                          ready_n,
  output logic [$clog2(SRAM_WORDS)-1:0] sram_addr,
  output logic [DW-1:0]                 sram_wdata,
  output logic [DW/8-1:0]               sram_be,
  output logic                          sram_we,
  output logic                          sram_re,
  input  logic [DW-1:0]                 sram_rdata
);
  localparam int BEW     = DW / 8;
  localparam int SRAM_AW = $clog2(SRAM_WORDS);

  logic               hit;
  logic [SRAM_AW-1:0] off;
  logic               owner_open;
  logic               acc_busy;
  logic               start;
  logic               done;

  lbsr_decode #(
    .LA_W(LA_W), .BEW(BEW), .SRAM_WORDS(SRAM_WORDS), .WIN_BASE(WIN_BASE)
  ) u_decode (
    .la(la), .hit(hit), .off(off)
  );

  assign start = owner_open && hold_req && !ads_n && hit;

  lbsr_grant #(.TIMEOUT(TIMEOUT)) u_grant (
    .clk(clk), .rst(rst), .hold_req(hold_req), .local_busy(local_busy),
    .start(start), .done(done), .hold_ack(hold_ack),
    .owner_open(owner_open), .acc_busy(acc_busy)
  );

  lbsr_beat #(.DW(DW), .BEW(BEW), .SRAM_AW(SRAM_AW)) u_beat (
    .clk(clk), .rst(rst), .start(start), .start_wr(wr_sel),
    .start_be_n(be_n), .start_off(off), .blast_n(blast_n),
    .ld_in(ld_in), .sram_rdata(sram_rdata), .done(done),
    .ready_n(ready_n), .ld_oe(ld_oe), .ld_out(ld_out),
    .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_be(sram_be),
    .sram_we(sram_we), .sram_re(sram_re)
  );
endmodule

// File: rtl/lbsr_checker.sv
module lbsr_checker #(
  parameter int TIMEOUT = 12
) (
  input logic clk,
  input logic rst,
  input logic hold_req,
  input logic local_busy,
  input logic hold_ack,
  input logic ready_n,
  input logic ld_oe,
  input logic sram_we,
  input logic sram_re,
  input logic acc_busy
);
  localparam int KW = $clog2(TIMEOUT + 2);

  logic [KW-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (rst) idle_cnt <= '0;
    else if (hold_ack && !acc_busy) begin
      if (idle_cnt != {KW{1'b1}}) idle_cnt <= idle_cnt + KW'(1);
    end else idle_cnt <= '0;
  end

  // R1: a grant is caused by a sampled request on an idle bus
  p_grant_cause_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_ack) |-> $past(hold_req && !local_busy));

  // R2: an idle grant lasts no longer than the timeout
  p_timeout_bound_r2: assert property (@(posedge clk) disable iff (rst)
    idle_cnt <= KW'(TIMEOUT));

  // R4: read and write strobes never overlap
  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(sram_we && sram_re));

  // R5: a write strobe follows a ready beat
  p_write_after_ready_r5: assert property (@(posedge clk) disable iff (rst)
    sram_we |-> $past(!ready_n));

  // R6: one wait state separates ready clocks
  p_wait_state_r6: assert property (@(posedge clk) disable iff (rst)
    !ready_n |=> ready_n);

  // R7: data is driven only in a ready clock
  p_drive_in_ready_r7: assert property (@(posedge clk) disable iff (rst)
    ld_oe |-> !ready_n);

  // R10: beats happen only inside a tenure
  p_ready_in_tenure_r10: assert property (@(posedge clk) disable iff (rst)
    !ready_n |-> hold_ack);
endmodule

bind lbus_sram_resp lbsr_checker #(.TIMEOUT(TIMEOUT)) u_lbsr_chk (
  .clk(clk), .rst(rst), .hold_req(hold_req), .local_busy(local_busy),
  .hold_ack(hold_ack), .ready_n(ready_n), .ld_oe(ld_oe),
  .sram_we(sram_we), .sram_re(sram_re), .acc_busy(acc_busy)
);

// File: tb/lbus_sram_resp_bench.sv
module lbus_sram_resp_bench;
  localparam int WORDS   = 256;
  localparam int TIMEOUT = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hold_req = 1'b0, local_busy = 1'b0;
  logic        ads_n = 1'b1, blast_n = 1'b1, wr_sel = 1'b0;
  logic [3:0]  be_n = 4'hF;
  logic [15:0] la = '0;
  logic [31:0] ld_in = '0;
  logic        hold_ack, ld_oe, ready_n, sram_we, sram_re;
  logic [31:0] ld_out, sram_wdata, sram_rdata;
  logic [7:0]  sram_addr;
  logic [3:0]  sram_be;

  logic [31:0] sram_mem [WORDS];
  logic [31:0] exp_mem  [WORDS];
  logic [31:0] beat_data [4];
  int checks = 0, failures = 0, clash = 0;

  lbus_sram_resp u_lbus_sram_resp (
    .clk(clk), .rst(rst), .hold_req(hold_req), .local_busy(local_busy),
    .hold_ack(hold_ack), .ads_n(ads_n), .blast_n(blast_n), .wr_sel(wr_sel),
    .be_n(be_n), .la(la), .ld_in(ld_in), .ld_out(ld_out), .ld_oe(ld_oe),
    .ready_n(ready_n), .sram_addr(sram_addr), .sram_wdata(sram_wdata),
    .sram_be(sram_be), .sram_we(sram_we), .sram_re(sram_re),
    .sram_rdata(sram_rdata)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (sram_re) sram_rdata <= sram_mem[sram_addr];
    if (sram_we)
      for (int i = 0; i < 4; i++)
        if (sram_be[i]) sram_mem[sram_addr][8*i +: 8] <= sram_wdata[8*i +: 8];
  end

  always @(negedge clk) if (!rst && sram_we && sram_re) clash++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old_w, input logic [31:0] new_w,
                                        input logic [3:0] ben);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = ben[i] ? old_w[8*i +: 8] : new_w[8*i +: 8];
    return r;
  endfunction

  task automatic acquire();
    hold_req = 1'b1;
    @(negedge clk);
    check("R1 grant one clock after request", {31'd0, hold_ack}, 32'd1);
  endtask

  task automatic release_bus();
    hold_req = 1'b0;
    @(negedge clk);
    check("R10 grant drops after request falls", {31'd0, hold_ack}, 32'd0);
    @(negedge clk);
  endtask

  task automatic access(input bit wr, input int word, input logic [3:0] ben, input int nb);
    ads_n   = 1'b0;
    la      = 16'h4000 + 16'(word * 4);
    wr_sel  = wr;
    be_n    = ben;
    blast_n = (nb == 1) ? 1'b0 : 1'b1;
    ld_in   = beat_data[0];
    @(negedge clk);
    ads_n  = 1'b1;
    la     = 16'($urandom);
    be_n   = 4'($urandom);
    wr_sel = ~wr;
    for (int b = 0; b < nb; b++) begin
      int waited = 0;
      do begin @(negedge clk); waited++; end while (ready_n && waited < 6);
      check("R6 ready after one wait state", waited, 1);
      if (wr) begin
        check("R7 no drive on write beat", {31'd0, ld_oe}, 32'd0);
        exp_mem[word + b] = merge(exp_mem[word + b], beat_data[b], ben);
      end else begin
        check("R7 drive on read beat", {31'd0, ld_oe}, 32'd1);
        check("R3 R8 R5 read data", ld_out, exp_mem[word + b]);
      end
      @(negedge clk);
      if (b + 1 < nb) begin
        ld_in   = beat_data[b + 1];
        blast_n = (b + 2 == nb) ? 1'b0 : 1'b1;
      end else blast_n = 1'b1;
    end
  endtask

  task automatic idle_grant(input logic [15:0] addr, input bit strobe, input string tag);
    int n = 1, bad = 0;
    acquire();
    if (strobe) begin
      ads_n = 1'b0; la = addr; wr_sel = 1'b0; be_n = 4'h0; blast_n = 1'b0;
    end
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      ads_n = 1'b1; blast_n = 1'b1;
      if (!ready_n || ld_oe || sram_re || sram_we) bad++;
      if (!hold_ack) break;
      n++;
    end
    check({tag, " grant length"}, n, TIMEOUT);
    check("R9 no response to ignored access", bad, 0);
    repeat (3) begin
      @(negedge clk);
      check("R2 no regrant while request held", {31'd0, hold_ack}, 32'd0);
    end
    release_bus();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED1234);
    repeat (3) @(negedge clk);
    check("R1 reset grant low", {31'd0, hold_ack}, 32'd0);
    check("R6 reset ready high", {31'd0, ready_n}, 32'd1);
    check("R7 reset no drive", {31'd0, ld_oe}, 32'd0);
    check("R4 reset strobes low", {30'd0, sram_we, sram_re}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // R1: busy bus blocks grant
    local_busy = 1'b1; hold_req = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check("R1 no grant while bus busy", {31'd0, hold_ack}, 32'd0);
    end
    local_busy = 1'b0;
    @(negedge clk);
    check("R1 grant once bus free", {31'd0, hold_ack}, 32'd1);

    // R10: fill whole window with bursts inside one tenure
    for (int w = 0; w < WORDS; w += 4) begin
      for (int b = 0; b < 4; b++) beat_data[b] = 32'hA5000000 ^ (32'(w + b) * 32'h01010101);
      for (int b = 0; b < 4; b++) exp_mem[w + b] = 32'h0;
      access(1'b1, w, 4'h0, 4);
    end
    release_bus();

    // R2: no strobe at all
    idle_grant(16'h0000, 1'b0, "R2 timeout");
    // R9: one word past the window end and one word below its base
    idle_grant(16'h4400, 1'b1, "R9 miss above");
    idle_grant(16'h3FFC, 1'b1, "R9 miss below");

    // R5: last word, partial enables, then read back in the same tenure
    acquire();
    beat_data[0] = 32'h11223344;
    access(1'b1, WORDS - 1, 4'b0101, 1);
    access(1'b0, WORDS - 1, 4'h0, 1);
    release_bus();

    // R8: random bursts and enables
    for (int t = 0; t < 40; t++) begin
      int nb, word;
      bit wr;
      logic [3:0] ben;
      nb   = $urandom_range(1, 4);
      word = $urandom_range(0, WORDS - nb);
      wr   = 1'($urandom_range(0, 1));
      ben  = 4'($urandom);
      for (int b = 0; b < 4; b++) beat_data[b] = $urandom;
      acquire();
      access(wr, word, ben, nb);
      if ($urandom_range(0, 1) == 1) access(1'b0, word, 4'h0, nb);
      release_bus();
    end

    check("R4 strobes never overlap", clash, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule